// File: doc/BRIEF.md
# I2C Command Byte Transaction Decoder

This block sits behind a byte-level I2C target front end. That front end has already resolved START, repeated START, STOP, address match and acknowledge. What reaches this block is a strobe for each written byte, a strobe for each byte the controller wants to read, and strobes for start and stop conditions. The first byte written after each start condition is decoded as a command. The command's leading bits choose between two kinds of transaction: a memory write, or an access to a 16-bit register.

In a memory write, a 6-bit bank number, a big-endian byte address and a stream of data bytes go to a bank write port. The address advances by one for every data byte the port accepts. A register access carries a 7-bit register number. A write supplies the new value as two big-endian bytes in the same transaction. A read uses a repeated start in read mode and receives the value high byte first.

Malformed commands and writes to banks that are not available raise sticky error flags. Register 0 always identifies the device with a fixed constant.

Top module: `cmd_xact_decoder`

## Requirements
- R1: The first byte written after a start strobe is taken as the command. Bytes written while no transaction is open (after reset or after a stop, with no start since) cause no write and no state change.
- R2: A command with bit 7 = 1 opens a register access, and `reg_num_o` then shows command bits 6..0. The memory and register write strobes are never high in the same cycle.
- R3: A command with bits 7..6 = 00 opens a memory write with bank = bits 5..0 on `mem_bank_o`. The next four written bytes form the start address, most significant byte first.
- R4: A command with bits 7..6 = 01 sets the sticky `cmd_err_o`. The rest of that transaction produces no write strobe, and its reads return 0x00. A later start with a valid command works normally.
- R5: Each data byte after the address raises `mem_we_o` for one cycle, in the cycle after the byte strobe. The address starts at the start address and increments by one per accepted byte, wrapping modulo 2^32. After a stop, data bytes are ignored.
- R6: A data byte is dropped when the bank's bit in `bank_avail_i` is 0 or the bank number is at least NUM_BANKS. The sticky `bank_err_o` is then set.
- R7: In a register access, each read request returns one byte on `rd_data_o` with `rd_valid_o` high, in the cycle after the request. Byte 0 is value bits 15..8 and byte 1 is bits 7..0. The byte count restarts at every start strobe.
- R8: Read requests beyond the second byte of a register return 0x00. Reads outside a register access also return 0x00.
- R9: Register 0 reads 0x9DF2 whatever `reg_rdata_i` holds.
- R10: In a register access, the two bytes after the command raise `reg_we_o` for one cycle after the second byte, with `reg_wdata_o` = {first, second}. Further bytes in that transaction are ignored.
- R11: A stop after only one value byte discards it. No register write occurs, and the next transaction assembles its value from scratch.
- R12: After reset all strobes are low, both error flags are clear and `rd_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated start seen |
| stop_i | input | 1 | Stop seen |
| wr_valid_i | input | 1 | Written byte available |
| wr_byte_i | input | 8 | Written byte |
| rd_req_i | input | 1 | Controller requests a read byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| mem_we_o | output | 1 | Bank write strobe |
| mem_bank_o | output | 6 | Bank number |
| mem_addr_o | output | 32 | Bank byte address |
| mem_wdata_o | output | 8 | Bank write data |
| bank_avail_i | input | NUM_BANKS | Per-bank availability |
| bank_err_o | output | 1 | Sticky: write to unavailable bank |
| reg_num_o | output | 7 | Selected register number |
| reg_rdata_i | input | 16 | Register file read value for `reg_num_o` |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 16 | Register write value |
| cmd_err_o | output | 1 | Sticky: unused command code |

## Verification
The bound assertions check several rules on every cycle. A write strobe of either kind only follows an accepted byte, and the two never coincide. A memory strobe only reaches a bank whose availability bit was set. Both error flags stay set once raised. Read data appears exactly one cycle after a request. Only the bench's scenarios can show the rest: big-endian address assembly, address increment and wrap, the magic constant, zero padding after two read bytes, the discard of a half-written value on stop, and recovery after a bad command.

// File: rtl/cxd_pkg.sv
package cxd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_MADDR = 3'd1,
    PH_MDATA = 3'd2,
    PH_REG   = 3'd3,
    PH_DROP  = 3'd4
  } phase_t;

  localparam int CMD_PARAM_W = 7;
  localparam int BANK_W      = 6;
endpackage

// File: rtl/cxd_cmd_fsm.sv
module cxd_cmd_fsm
  import cxd_pkg::*;
#(
  parameter int ADDR_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   byte_valid_i,
  input  logic [7:0]             byte_i,
  output phase_t                 phase_o,
  output logic [CMD_PARAM_W-1:0] param_o,
  output logic                   addr_byte_o,
  output logic                   data_byte_o,
  output logic                   reg_byte_o,
  output logic                   cmd_err_o
);
  localparam int AW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [AW-1:0] ALAST = AW'(ADDR_BYTES - 1);

  phase_t                 phase_q, phase_d;
  logic                   pend_q, pend_d;
  logic [CMD_PARAM_W-1:0] param_q, param_d;
  logic [AW-1:0]          acnt_q, acnt_d;
  logic                   err_q, err_d;

  always_comb begin
    phase_d     = phase_q;
    pend_d      = pend_q;
    param_d     = param_q;
    acnt_d      = acnt_q;
    err_d       = err_q;
    addr_byte_o = 1'b0;
    data_byte_o = 1'b0;
    reg_byte_o  = 1'b0;
    if (stop_i) begin
      phase_d = PH_IDLE;
      pend_d  = 1'b0;
    end else if (start_i) begin
      pend_d = 1'b1;
    end else if (byte_valid_i) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (byte_i[7]) begin
          phase_d = PH_REG;
          param_d = byte_i[6:0];
        end else if (!byte_i[6]) begin
          phase_d = PH_MADDR;
          param_d = {1'b0, byte_i[5:0]};
          acnt_d  = '0;
        end else begin
          phase_d = PH_DROP;
          err_d   = 1'b1;
        end
      end else begin
        case (phase_q)
          PH_MADDR: begin
            addr_byte_o = 1'b1;
            acnt_d      = acnt_q + 1'b1;
            if (acnt_q == ALAST) phase_d = PH_MDATA;
          end
          PH_MDATA: data_byte_o = 1'b1;
          PH_REG:   reg_byte_o  = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= 1'b0;
      param_q <= '0;
      acnt_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      param_q <= param_d;
      acnt_q  <= acnt_d;
      err_q   <= err_d;
    end
  end

  assign phase_o   = phase_q;
  assign param_o   = param_q;
  assign cmd_err_o = err_q;
endmodule

// File: rtl/cxd_mem_path.sv
module cxd_mem_path
  import cxd_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [NUM_BANKS-1:0]    bank_avail_i,
  input  logic                    addr_byte_i,
  input  logic                    data_byte_i,
  input  logic [7:0]              byte_i,
  output logic                    mem_we_o,
  output logic [8*ADDR_BYTES-1:0] mem_addr_o,
  output logic [7:0]              mem_wdata_o,
  output logic                    bank_err_o
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int AVW    = 1 << BANK_W;

  logic [AVW-1:0]    avail_ext;
  logic              bank_ok;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [7:0]        wdata_q, wdata_d;
  logic              we_q, we_d;
  logic              err_q, err_d;

  assign avail_ext = AVW'(bank_avail_i);
  assign bank_ok   = avail_ext[bank_i];

  always_comb begin
    addr_d  = addr_q;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    err_d   = err_q;
    if (addr_byte_i) begin
      addr_d = {addr_q[ADDR_W-9:0], byte_i};
    end else if (data_byte_i) begin
      if (bank_ok) begin
        we_d    = 1'b1;
        waddr_d = addr_q;
        wdata_d = byte_i;
        addr_d  = addr_q + 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      err_q   <= err_d;
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = waddr_q;
  assign mem_wdata_o = wdata_q;
  assign bank_err_o  = err_q;
endmodule

// File: rtl/cxd_reg_path.sv
module cxd_reg_path
  import cxd_pkg::*;
#(
  parameter int             REG_BYTES = 2,
  parameter logic [15:0]    MAGIC     = 16'h9DF2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   reg_sel_i,
  input  logic                   reg_byte_i,
  input  logic [7:0]             byte_i,
  input  logic                   rd_req_i,
  input  logic [CMD_PARAM_W-1:0] reg_num_i,
  input  logic [8*REG_BYTES-1:0] reg_rdata_i,
  output logic                   reg_we_o,
  output logic [8*REG_BYTES-1:0] reg_wdata_o,
  output logic                   rd_valid_o,
  output logic [7:0]             rd_data_o
);
  localparam int REG_W = 8 * REG_BYTES;
  localparam int CW    = $clog2(REG_BYTES + 1);
  localparam logic [CW-1:0] CFULL = CW'(REG_BYTES);
  localparam logic [CW-1:0] CLAST = CW'(REG_BYTES - 1);

  logic [CW-1:0]    wcnt_q, wcnt_d;
  logic [REG_W-1:0] wbuf_q, wbuf_d;
  logic             we_q, we_d;
  logic [CW-1:0]    ridx_q, ridx_d;
  logic [7:0]       rdat_q, rdat_d;
  logic             rval_q, rval_d;
  logic [REG_W-1:0] value;
  logic [REG_W-1:0] shifted;

  assign value   = (reg_num_i == '0) ? REG_W'(MAGIC) : reg_rdata_i;
  assign shifted = value >> (8 * (REG_BYTES - 1 - int'(ridx_q)));

  always_comb begin
    wcnt_d = wcnt_q;
    wbuf_d = wbuf_q;
    we_d   = 1'b0;
    ridx_d = ridx_q;
    rdat_d = rdat_q;
    rval_d = 1'b0;
    if (start_i || stop_i) begin
      wcnt_d = '0;
      ridx_d = '0;
    end else begin
      if (reg_byte_i && (wcnt_q != CFULL)) begin
        wbuf_d = {wbuf_q[REG_W-9:0], byte_i};
        wcnt_d = wcnt_q + 1'b1;
        we_d   = (wcnt_q == CLAST);
      end
      if (rd_req_i) begin
        rval_d = 1'b1;
        rdat_d = (reg_sel_i && (ridx_q != CFULL)) ? shifted[7:0] : 8'h00;
        if (ridx_q != CFULL) ridx_d = ridx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      wbuf_q <= '0;
      we_q   <= 1'b0;
      ridx_q <= '0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      wbuf_q <= wbuf_d;
      we_q   <= we_d;
      ridx_q <= ridx_d;
      rdat_q <= rdat_d;
      rval_q <= rval_d;
    end
  end

  assign reg_we_o    = we_q;
  assign reg_wdata_o = wbuf_q;
  assign rd_valid_o  = rval_q;
  assign rd_data_o   = rdat_q;
endmodule

// File: rtl/cmd_xact_decoder.sv
module cmd_xact_decoder
  import cxd_pkg::*;
#(
  parameter int          NUM_BANKS  = 4,
  parameter int          ADDR_BYTES = 4,
  parameter int          REG_BYTES  = 2,
  parameter logic [15:0] MAGIC      = 16'h9DF2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    wr_valid_i,
  input  logic [7:0]              wr_byte_i,
  input  logic                    rd_req_i,
  output logic                    rd_valid_o,
  output logic [7:0]              rd_data_o,
  output logic                    mem_we_o,
  output logic [BANK_W-1:0]       mem_bank_o,
  output logic [8*ADDR_BYTES-1:0] mem_addr_o,
  output logic [7:0]              mem_wdata_o,
  input  logic [NUM_BANKS-1:0]    bank_avail_i,
  output logic                    bank_err_o,
  output logic [CMD_PARAM_W-1:0]  reg_num_o,
  input  logic [8*REG_BYTES-1:0]  reg_rdata_i,
  output logic                    reg_we_o,
  output logic [8*REG_BYTES-1:0]  reg_wdata_o,
  output logic                    cmd_err_o
);
  logic [1:0]             rst_sync_q;
  logic                   core_rst_n;
  phase_t                 phase;
  logic [CMD_PARAM_W-1:0] param;
  logic                   addr_byte, data_byte, reg_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cxd_cmd_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (wr_valid_i),
    .byte_i       (wr_byte_i),
    .phase_o      (phase),
    .param_o      (param),
    .addr_byte_o  (addr_byte),
    .data_byte_o  (data_byte),
    .reg_byte_o   (reg_byte),
    .cmd_err_o    (cmd_err_o)
  );

  cxd_mem_path #(.NUM_BANKS(NUM_BANKS), .ADDR_BYTES(ADDR_BYTES)) u_mem (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .bank_i       (param[BANK_W-1:0]),
    .bank_avail_i (bank_avail_i),
    .addr_byte_i  (addr_byte),
    .data_byte_i  (data_byte),
    .byte_i       (wr_byte_i),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .bank_err_o   (bank_err_o)
  );

  cxd_reg_path #(.REG_BYTES(REG_BYTES), .MAGIC(MAGIC)) u_reg (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .reg_sel_i    (phase == PH_REG),
    .reg_byte_i   (reg_byte),
    .byte_i       (wr_byte_i),
    .rd_req_i     (rd_req_i),
    .reg_num_i    (param),
    .reg_rdata_i  (reg_rdata_i),
    .reg_we_o     (reg_we_o),
    .reg_wdata_o  (reg_wdata_o),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
  );

  assign mem_bank_o = param[BANK_W-1:0];
  assign reg_num_o  = param;
endmodule

// File: rtl/cxd_checker.sv
module cxd_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_valid_i,
  input logic                 rd_req_i,
  input logic                 rd_valid_o,
  input logic                 mem_we_o,
  input logic [5:0]           mem_bank_o,
  input logic [NUM_BANKS-1:0] bank_avail_i,
  input logic                 bank_err_o,
  input logic                 reg_we_o,
  input logic                 cmd_err_o
);
  logic [63:0] avail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= '0;
    else        avail_q <= 64'(bank_avail_i);
  end

  AST_MEM_WE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(wr_valid_i)); // R5
  AST_MEM_WE_BANK_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> avail_q[mem_bank_o]); // R6
  AST_BANK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bank_err_o |=> bank_err_o); // R6
  AST_CMD_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_o |=> cmd_err_o); // R4
  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && reg_we_o)); // R2
  AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_req_i)); // R7
  AST_REG_WE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> $past(wr_valid_i)); // R10
  AST_REG_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o); // R10
endmodule

bind cmd_xact_decoder cxd_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid_i   (wr_valid_i),
  .rd_req_i     (rd_req_i),
  .rd_valid_o   (rd_valid_o),
  .mem_we_o     (mem_we_o),
  .mem_bank_o   (mem_bank_o),
  .bank_avail_i (bank_avail_i),
  .bank_err_o   (bank_err_o),
  .reg_we_o     (reg_we_o),
  .cmd_err_o    (cmd_err_o)
);

// File: tb/cmd_xact_decoder_tb.sv
`timescale 1ns/1ps
module cmd_xact_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, wr_valid_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0]  wr_byte_i = 8'h00;
  logic        rd_valid_o, mem_we_o, bank_err_o, reg_we_o, cmd_err_o;
  logic [7:0]  rd_data_o, mem_wdata_o;
  logic [5:0]  mem_bank_o;
  logic [31:0] mem_addr_o;
  logic [3:0]  bank_avail_i = 4'b0101;
  logic [6:0]  reg_num_o;
  logic [15:0] reg_rdata_i, reg_wdata_o;

  int checks = 0, failures = 0;
  int mem_cnt = 0, reg_cnt = 0;
  logic [31:0] last_addr;
  logic [7:0]  last_data;
  logic [15:0] last_wval;
  logic [7:0]  rb;

  always #4 clk = ~clk;

  assign reg_rdata_i = {1'b0, reg_num_o, 8'hA5 ^ {1'b0, reg_num_o}};

  cmd_xact_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .wr_valid_i(wr_valid_i), .wr_byte_i(wr_byte_i), .rd_req_i(rd_req_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .mem_we_o(mem_we_o),
    .mem_bank_o(mem_bank_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .bank_avail_i(bank_avail_i), .bank_err_o(bank_err_o), .reg_num_o(reg_num_o),
    .reg_rdata_i(reg_rdata_i), .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o),
    .cmd_err_o(cmd_err_o)
  );

  // {command, expected 16-bit value}: reg N returns {0,N, A5^{0,N}}, reg 0 the constant
  localparam logic [23:0] RD_VEC [5] = '{
    24'h809DF2, 24'h8101A4, 24'hFF7FDA, 24'hC343E6, 24'h9717B2
  };

  always @(negedge clk) begin
    if (mem_we_o) begin
      mem_cnt++; last_addr = mem_addr_o; last_data = mem_wdata_o;
    end
    if (reg_we_o) begin
      reg_cnt++; last_wval = reg_wdata_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask
  task automatic wr(input logic [7:0] b);
    @(negedge clk) begin wr_valid_i = 1'b1; wr_byte_i = b; end
    @(negedge clk) wr_valid_i = 1'b0;
    #1;
  endtask
  task automatic rd(output logic [7:0] b);
    @(negedge clk) rd_req_i = 1'b1;
    @(negedge clk) begin b = rd_data_o; rd_req_i = 1'b0; end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 strobes", {mem_we_o, reg_we_o, rd_valid_o}, 0);
    chk("R12 errors", {bank_err_o, cmd_err_o}, 0);
    chk("R12 rd_data", rd_data_o, 8'h00);

    // R1: bytes with no open transaction do nothing
    wr(8'h85); wr(8'h12); wr(8'h34);
    chk("R1 no write before start", reg_cnt + mem_cnt, 0);

    // R7 R8 R9 R2: read table
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b0, b1, b2;
      pulse_start(); wr(RD_VEC[i][23:16]);
      pulse_start();
      rd(b0); rd(b1); rd(b2);
      pulse_stop();
      chk("R2 reg_num", reg_num_o, RD_VEC[i][22:16]);
      chk("R7 R9 high byte", b0, RD_VEC[i][15:8]);
      chk("R7 R9 low byte", b1, RD_VEC[i][7:0]);
      chk("R8 pad byte", b2, 8'h00);
    end

    // R10 register write, extra byte ignored
    pulse_start(); wr(8'h85); wr(8'hBE);
    chk("R10 no write after one byte", reg_cnt, 0);
    wr(8'hEF);
    chk("R10 write count", reg_cnt, 1);
    chk("R10 write value", last_wval, 16'hBEEF);
    chk("R10 reg_num", reg_num_o, 7'h05);
    wr(8'h77);
    chk("R10 third byte ignored", reg_cnt, 1);
    pulse_stop();

    // R11 stop after one byte discards it
    pulse_start(); wr(8'h86); wr(8'h11); pulse_stop();
    chk("R11 discarded", reg_cnt, 1);
    pulse_start(); wr(8'h86); wr(8'h22); wr(8'h33); pulse_stop();
    chk("R11 fresh value", last_wval, 16'h2233);
    chk("R11 count", reg_cnt, 2);

    // R3 R5 memory burst to available bank 2
    pulse_start(); wr(8'h02);
    chk("R3 bank", mem_bank_o, 6'd2);
    wr(8'h12); wr(8'h34); wr(8'h56); wr(8'h78);
    chk("R3 no write during address", mem_cnt, 0);
    wr(8'hAA);
    chk("R3 first address", last_addr, 32'h12345678);
    chk("R5 data0", last_data, 8'hAA);
    wr(8'hBB); wr(8'hCC);
    chk("R5 increment", last_addr, 32'h1234567A);
    chk("R5 data2", last_data, 8'hCC);
    chk("R5 count", mem_cnt, 3);
    pulse_stop();
    wr(8'hDD);
    chk("R5 after stop ignored", mem_cnt, 3);

    // R5 wrap
    pulse_start(); wr(8'h00); wr(8'hFF); wr(8'hFF); wr(8'hFF); wr(8'hFF);
    wr(8'h01);
    chk("R5 wrap start", last_addr, 32'hFFFFFFFF);
    wr(8'h02);
    chk("R5 wrap", last_addr, 32'h00000000);
    pulse_stop();

    // R6 unavailable bank and out-of-range bank
    pulse_start(); wr(8'h01); wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h10); wr(8'h55);
    chk("R6 dropped", mem_cnt, 5);
    chk("R6 bank_err", bank_err_o, 1'b1);
    chk("R4 cmd_err clear", cmd_err_o, 1'b0);
    pulse_stop();
    pulse_start(); wr(8'h3F); wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h66);
    chk("R6 out of range dropped", mem_cnt, 5);
    pulse_stop();

    // R4 unused command code
    pulse_start(); wr(8'h45); wr(8'h02); wr(8'h80); wr(8'h12);
    chk("R4 cmd_err", cmd_err_o, 1'b1);
    chk("R4 no writes", mem_cnt + reg_cnt, 5 + 2);
    pulse_start(); rd(rb);
    chk("R4 read zero", rb, 8'h00);
    pulse_stop();
    pulse_start(); wr(8'h80); pulse_start(); rd(rb); pulse_stop();
    chk("R4 recovery", rb, 8'h9D);
    chk("R4 sticky", cmd_err_o, 1'b1);

    // R8 read outside register access
    rd(rb);
    chk("R8 idle read", rb, 8'h00);

    finish_run();
  end
endmodule